// File: doc/BRIEF.md
# Low-Power Wake Controller

This block is the power-mode sequencer of a small microcontroller. Software asks for one of two low-power states through a small register port. In the suspend state the system clock gate and the internal oscillator enables are switched off. In the sleep state the regulator enable is also dropped, the core power domain is isolated and the digital output pins are held at their last value. The block leaves either state when an enabled wake event arrives. It records the cause in sticky flags, and software reads those flags once the system clock runs again.

The wake inputs are sampled by an always-on low-frequency clock. Each input is first passed through synchronising flops, then turned into an edge pulse, and that pulse is passed through two flops into the system clock domain. Four wake sources each have their own enable: a real-time-clock oscillator failure, a real-time-clock alarm, a port-match event and a comparator rising edge. A falling edge on the reset pin always wakes the block, even when the edge is too short to reset the device. After a reset-pin wake, a programmable lockout holds off any new mode request, so that a real pin reset can still be recognised. Mode entry is allowed only while the global clock divider field is zero (divide by 1).

Register map (byte-wide data, 2-bit address): address 0 is control and status, address 1 holds the wake enables, address 2 holds the wake flags, address 3 holds the lockout length in system clocks.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: Writing address 0 with bit 0 set and bit 1 clear, while `clkDiv` is 0, enters suspend on that clock edge: from the next cycle `sysClkEn` and `oscEn` are 0, `regulatorEn` stays 1, and `coreIso` and `gpioHold` stay 0.
- R2: Writing address 0 with bit 1 set enters sleep. Sleep takes priority over bit 0. From the next cycle `sysClkEn`, `oscEn` and `regulatorEn` are 0, and `coreIso` and `gpioHold` are 1.
- R3: The wake enables sit at address 1: bit 0 oscillator fail, bit 1 alarm, bit 2 port match, bit 3 comparator. Each bit arms the rising edge of `wakeSrc` at the same index. A rising edge on an enabled source during suspend or sleep returns the block to run, with all five outputs at their run values. An edge on a disabled source leaves the block in its low-power state.
- R4: A falling edge on `rstPinN` during suspend or sleep always wakes the block, whatever the enables hold.
- R5: The wake flags sit at address 2. Bits 3:0 follow the source order of R3 and bit 4 marks a reset-pin wake. A flag is set only by an armed event seen while in a low-power state. Every source that fires in the same low-frequency cycle sets its own flag. Flags stay set across later wakes until software writes 1 to their bit position, and a 0 written to a bit leaves that flag unchanged.
- R6: During the first two system clocks after a wake, address 2 reads as 0. From the third clock onward it reads the true flag values.
- R7: A mode request written while `clkDiv` is not 0 is ignored, and the block stays in run. The request sets the sticky entry-error bit, bit 7 of address 0, which is cleared by writing address 0 with bit 7 set.
- R8: A reset-pin wake loads a lockout counter from address 3. Bit 0 of address 0 reads 1 while the counter is non-zero. A valid request made during the lockout is held pending and is entered one cycle after the lockout bit first reads 0.
- R9: Wake edges that occur while the block is running change neither the clock enables nor the flags.
- R10: After reset, `sysClkEn`, `oscEn` and `regulatorEn` are 1, `coreIso` and `gpioHold` are 0, and all four registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated system root clock |
| lfClk | input | 1 | Always-on low-frequency clock that samples the wake inputs |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on the address) |
| clkDiv | input | 3 | Current global clock divider field; 0 means divide by 1 |
| wakeSrc | input | 4 | Wake inputs: oscillator fail, alarm, port match, comparator |
| rstPinN | input | 1 | Reset pin level; a falling edge is a wake event |
| sysClkEn | output | 1 | System clock gate enable |
| oscEn | output | 1 | Internal oscillator enable |
| regulatorEn | output | 1 | Core regulator enable |
| coreIso | output | 1 | Core power-domain isolation |
| gpioHold | output | 1 | Holds the digital output pins at their last value |

## Verification
The assertions check on every cycle that the five power outputs only ever take the run, suspend or sleep combination. They also check that a refused request leaves the clock running, that the lockout keeps the clock running for as long as it lasts, and that the flag register reads zero in the cycle the clock comes back. Other behaviour can only be shown by the bench's scenarios: which source is allowed to wake the block under each enable mask, how flags from simultaneous sources combine, how flags accumulate and are partly cleared, the exact cycle when the third-clock flag value appears, and the one-cycle step from lockout expiry to entry of the pending request.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_SUSPEND = 2'd1,
    PM_SLEEP   = 2'd2
  } pmState_t;

  // Strobes from the mode sequencer into the register datapath.
  typedef struct packed {
    logic capture;   // block is in a low-power state: record armed events
    logic wakeNow;   // leaving the low-power state on this edge
  } pmStrobe_t;

  localparam int REG_CTRL  = 0;
  localparam int REG_WKEN  = 1;
  localparam int REG_FLAGS = 2;
  localparam int REG_LOCK  = 3;

endpackage

// File: rtl/lpw_wake_sense.sv
module lpw_wake_sense #(
  parameter int SRC_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             lfClk,
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] srcLvl,
  output logic [SRC_W-1:0] evtHit
);

  // Always-on side: synchronise the raw levels, then form one-cycle edge pulses.
  logic [SRC_W-1:0] lfPipe [SYNC_STAGES+1];
  logic [SRC_W-1:0] lfEdge;

  always_ff @(posedge lfClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC_STAGES; i++) lfPipe[i] <= '0;
      lfEdge <= '0;
    end else begin
      lfPipe[0] <= srcLvl;
      for (int i = 1; i <= SYNC_STAGES; i++) lfPipe[i] <= lfPipe[i-1];
      lfEdge <= lfPipe[SYNC_STAGES-1] & ~lfPipe[SYNC_STAGES];
    end
  end

  // System side: synchronise the pulse and keep only its leading edge.
  logic [SRC_W-1:0] sysPipe [SYNC_STAGES+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i <= SYNC_STAGES; i++) sysPipe[i] <= '0;
    end else begin
      sysPipe[0] <= lfEdge;
      for (int i = 1; i <= SYNC_STAGES; i++) sysPipe[i] <= sysPipe[i-1];
    end
  end

  assign evtHit = sysPipe[SYNC_STAGES-1] & ~sysPipe[SYNC_STAGES];

endmodule

// File: rtl/lpw_datapath.sv
module lpw_datapath
  import lpw_pkg::*;
#(
  parameter int SRC_COUNT   = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int DIV_W       = 3,
  parameter int LOCK_W      = 8,
  parameter int MASK_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic [SRC_COUNT:0]   evtHit,
  input  pmStrobe_t            strobe,
  output logic                 reqValid,
  output logic                 reqSleep,
  output logic                 wakeHit,
  output logic                 lockBusy
);

  localparam int FLAG_W  = SRC_COUNT + 1;
  localparam int MASK_W  = $clog2(MASK_CYCLES + 1);
  localparam int ERR_BIT = DATA_W - 1;

  logic [SRC_COUNT-1:0] wakeEn;
  logic [FLAG_W-1:0]    flags;
  logic [LOCK_W-1:0]    lockCfg;
  logic [LOCK_W-1:0]    lockCnt;
  logic [MASK_W-1:0]    maskCnt;
  logic                 entryErr;

  logic selCtrl, selWken, selFlags, selLock;
  assign selCtrl  = regWrEn && (regAddr == ADDR_W'(REG_CTRL));
  assign selWken  = regWrEn && (regAddr == ADDR_W'(REG_WKEN));
  assign selFlags = regWrEn && (regAddr == ADDR_W'(REG_FLAGS));
  assign selLock  = regWrEn && (regAddr == ADDR_W'(REG_LOCK));

  logic reqAny, divOk;
  assign reqAny   = selCtrl && (regWrData[1:0] != 2'b00);
  assign divOk    = (clkDiv == '0);
  assign reqValid = reqAny && divOk;
  assign reqSleep = regWrData[1];

  // Reset-pin events are always armed.
  logic [FLAG_W-1:0] armMask, armedHit, flagSet, flagClr;
  assign armMask  = {1'b1, wakeEn};
  assign armedHit = evtHit & armMask;
  assign wakeHit  = |armedHit;
  assign flagSet  = strobe.capture ? armedHit : '0;
  assign flagClr  = selFlags ? regWrData[FLAG_W-1:0] : '0;
  assign lockBusy = (lockCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEn   <= '0;
      flags    <= '0;
      lockCfg  <= '0;
      lockCnt  <= '0;
      maskCnt  <= '0;
      entryErr <= 1'b0;
    end else begin
      if (selWken) wakeEn  <= regWrData[SRC_COUNT-1:0];
      if (selLock) lockCfg <= regWrData[LOCK_W-1:0];
      flags <= (flags & ~flagClr) | flagSet;

      if (reqAny && !divOk)               entryErr <= 1'b1;
      else if (selCtrl && regWrData[ERR_BIT]) entryErr <= 1'b0;

      if (strobe.wakeNow)       maskCnt <= MASK_W'(MASK_CYCLES);
      else if (maskCnt != '0)   maskCnt <= maskCnt - 1'b1;

      if (strobe.wakeNow && evtHit[SRC_COUNT]) lockCnt <= lockCfg;
      else if (lockBusy)                       lockCnt <= lockCnt - 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(REG_CTRL): begin
        regRdData[ERR_BIT] = entryErr;
        regRdData[0]       = lockBusy;
      end
      ADDR_W'(REG_WKEN):  regRdData[SRC_COUNT-1:0] = wakeEn;
      ADDR_W'(REG_FLAGS): if (maskCnt == '0) regRdData[FLAG_W-1:0] = flags;
      default:            regRdData[LOCK_W-1:0] = lockCfg;
    endcase
  end

endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
  import lpw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqSleep,
  input  logic      lockBusy,
  input  logic      wakeHit,
  output pmStrobe_t strobe,
  output logic      sysClkEn,
  output logic      oscEn,
  output logic      regulatorEn,
  output logic      coreIso,
  output logic      gpioHold
);

  pmState_t state;
  logic     pendValid;
  logic     pendSleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PM_RUN;
      pendValid <= 1'b0;
      pendSleep <= 1'b0;
    end else begin
      case (state)
        PM_RUN: begin
          if (reqValid && lockBusy) begin
            pendValid <= 1'b1;
            pendSleep <= reqSleep;
          end else if (reqValid) begin
            state     <= reqSleep ? PM_SLEEP : PM_SUSPEND;
            pendValid <= 1'b0;
          end else if (pendValid && !lockBusy) begin
            state     <= pendSleep ? PM_SLEEP : PM_SUSPEND;
            pendValid <= 1'b0;
          end
        end
        PM_SUSPEND, PM_SLEEP: begin
          if (wakeHit) state <= PM_RUN;
        end
        default: state <= PM_RUN;
      endcase
    end
  end

  assign strobe.capture = (state != PM_RUN);
  assign strobe.wakeNow = (state != PM_RUN) && wakeHit;

  assign sysClkEn    = (state == PM_RUN);
  assign oscEn       = (state == PM_RUN);
  assign regulatorEn = (state != PM_SLEEP);
  assign coreIso     = (state == PM_SLEEP);
  assign gpioHold    = (state == PM_SLEEP);

endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int SRC_COUNT   = 4,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int DIV_W       = 3,
  parameter int LOCK_W      = 8,
  parameter int MASK_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 lfClk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [DIV_W-1:0]     clkDiv,
  input  logic [SRC_COUNT-1:0] wakeSrc,
  input  logic                 rstPinN,
  output logic                 sysClkEn,
  output logic                 oscEn,
  output logic                 regulatorEn,
  output logic                 coreIso,
  output logic                 gpioHold
);

  localparam int EVT_W = SRC_COUNT + 1;

  logic [EVT_W-1:0] srcLvl;
  logic [EVT_W-1:0] evtHit;
  pmStrobe_t        strobe;
  logic             reqValid, reqSleep, wakeHit, lockBusy;

  // Reset pin is inverted so that its falling edge looks like a rising one.
  assign srcLvl = {~rstPinN, wakeSrc};

  lpw_wake_sense #(.SRC_W(EVT_W), .SYNC_STAGES(SYNC_STAGES)) u_sense (
    .lfClk (lfClk),
    .clk   (clk),
    .rstN  (rstN),
    .srcLvl(srcLvl),
    .evtHit(evtHit)
  );

  lpw_datapath #(
    .SRC_COUNT(SRC_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DIV_W(DIV_W), .LOCK_W(LOCK_W), .MASK_CYCLES(MASK_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .clkDiv   (clkDiv),
    .evtHit   (evtHit),
    .strobe   (strobe),
    .reqValid (reqValid),
    .reqSleep (reqSleep),
    .wakeHit  (wakeHit),
    .lockBusy (lockBusy)
  );

  lpw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqSleep   (reqSleep),
    .lockBusy   (lockBusy),
    .wakeHit    (wakeHit),
    .strobe     (strobe),
    .sysClkEn   (sysClkEn),
    .oscEn      (oscEn),
    .regulatorEn(regulatorEn),
    .coreIso    (coreIso),
    .gpioHold   (gpioHold)
  );

endmodule

// File: rtl/lpw_wake_ctrl_chk.sv
module lpw_wake_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int DIV_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [DIV_W-1:0]  clkDiv,
  input logic              sysClkEn,
  input logic              oscEn,
  input logic              regulatorEn,
  input logic              coreIso,
  input logic              gpioHold,
  input logic              lockBusy
);

  // R1: while running, every power output is at its run value.
  p_run_power_r1: assert property (@(posedge clk) disable iff (!rstN)
    sysClkEn |-> (oscEn && regulatorEn && !coreIso && !gpioHold));

  // R1: a gated clock always comes with the oscillators off.
  p_gate_osc_r1: assert property (@(posedge clk) disable iff (!rstN)
    !sysClkEn |-> !oscEn);

  // R2: regulator off only together with isolation, hold and gated clock.
  p_sleep_domain_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regulatorEn |-> (coreIso && gpioHold && !sysClkEn && !oscEn));

  // R6: flag register reads zero in the cycle the clock returns.
  p_flag_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sysClkEn) && regAddr == ADDR_W'(2)) |-> (regRdData == '0));

  // R7: a request with a non-unity divider never stops the clock.
  p_refuse_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0 && regWrData[1:0] != 2'b00 && clkDiv != '0
     && sysClkEn && !lockBusy && !$past(lockBusy)) |=> sysClkEn);

  // R8: no entry while the lockout counter runs.
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lockBusy && sysClkEn) |=> sysClkEn);

endmodule

bind lpw_wake_ctrl lpw_wake_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
) u_chk (.*);

// File: tb/tb_lpw_wake_ctrl.sv
module tb_lpw_wake_ctrl;

  logic       clk = 1'b0;
  logic       lfClk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [2:0] clkDiv = '0;
  logic [3:0] wakeSrc = '0;
  logic       rstPinN = 1'b1;
  logic       sysClkEn, oscEn, regulatorEn, coreIso, gpioHold;

  always #4 clk = ~clk;
  always #21 lfClk = ~lfClk;

  lpw_wake_ctrl dut (
    .clk(clk), .lfClk(lfClk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .clkDiv(clkDiv), .wakeSrc(wakeSrc), .rstPinN(rstPinN),
    .sysClkEn(sysClkEn), .oscEn(oscEn), .regulatorEn(regulatorEn),
    .coreIso(coreIso), .gpioHold(gpioHold)
  );

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [4:0] pwr();
    return {sysClkEn, oscEn, regulatorEn, coreIso, gpioHold};
  endfunction

  // Drive a pulse on the chosen inputs (bit 4 = reset pin glitch) and watch for a wake.
  task automatic fire(input logic [4:0] which, output bit woke,
                      output logic [7:0] flagsThird, output bit maskOk);
    int wakeCyc;
    woke = 1'b0; maskOk = 1'b1; flagsThird = '0; wakeCyc = 0;
    regAddr = 2'd2;
    wakeSrc = which[3:0];
    rstPinN = ~which[4];
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (c == 20) begin wakeSrc = '0; rstPinN = 1'b1; end
      #1;
      if (!woke && sysClkEn) begin woke = 1'b1; wakeCyc = c; end
      if (woke && (c == wakeCyc || c == wakeCyc + 1) && regRdData != 8'h00) maskOk = 1'b0;
      if (woke && c == wakeCyc + 2) flagsThird = regRdData;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit woke, mOk;
    logic [7:0] fl;
    int dropC, offC, violations;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R10: reset state
    check("R10", "power outputs", pwr(), 5'b11100);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R10", "register value", d, 8'h00);
    end

    // R3 R4 R5 R6 R1 R2: sweep both modes, every enable mask, every source
    for (int mode = 0; mode < 2; mode++) begin
      for (int mask = 0; mask < 16; mask++) begin
        for (int src = 0; src < 4; src++) begin
          wr(2'd1, 8'(mask));
          wr(2'd0, mode ? 8'h03 : 8'h01);
          #1;
          if (mode) check("R2", "sleep outputs", pwr(), 5'b00011);
          else      check("R1", "suspend outputs", pwr(), 5'b00100);
          fire(5'(1 << src), woke, fl, mOk);
          if (mask[src]) begin
            check("R3", "enabled source wakes", woke, 1);
            check("R6", "flags masked two clocks", mOk, 1);
            check("R5", "flag of waking source", fl, 8'(1 << src));
          end else begin
            check("R3", "disabled source ignored", woke, 0);
            check("R3", "still low power", pwr(), mode ? 5'b00011 : 5'b00100);
            fire(5'h10, woke, fl, mOk);
            check("R4", "reset pin wakes", woke, 1);
            check("R6", "flags masked after pin wake", mOk, 1);
            check("R4", "reset-pin flag", fl, 8'h10);
          end
          check("R3", "run outputs after wake", pwr(), 5'b11100);
          wr(2'd2, 8'h1f);
        end
      end
    end

    // R5: simultaneous sources, stickiness, partial clear
    wr(2'd1, 8'h0f);
    wr(2'd0, 8'h01);
    fire(5'h0f, woke, fl, mOk);
    check("R5", "all simultaneous flags", fl, 8'h0f);
    wr(2'd0, 8'h01);
    fire(5'h10, woke, fl, mOk);
    check("R5", "flags accumulate", fl, 8'h1f);
    wr(2'd2, 8'h05);
    rd(2'd2, d);
    check("R5", "write-one clears selected", d, 8'h1a);
    wr(2'd2, 8'h1f);
    rd(2'd2, d);
    check("R5", "all cleared", d, 8'h00);

    // R9: events while running
    fire(5'h1f, woke, fl, mOk);
    rd(2'd2, d);
    check("R9", "no flags while running", d, 8'h00);
    check("R9", "outputs unchanged", pwr(), 5'b11100);

    // R7: refused entry
    clkDiv = 3'd4;
    wr(2'd0, 8'h01);
    #1;
    check("R7", "suspend refused", pwr(), 5'b11100);
    rd(2'd0, d);
    check("R7", "entry error set", d[7], 1);
    wr(2'd0, 8'h80);
    rd(2'd0, d);
    check("R7", "entry error cleared", d[7], 0);
    wr(2'd0, 8'h02);
    #1;
    check("R7", "sleep refused", pwr(), 5'b11100);
    rd(2'd0, d);
    check("R7", "entry error set by sleep", d[7], 1);
    wr(2'd0, 8'h80);
    clkDiv = 3'd0;

    // R8: lockout after reset-pin wake
    wr(2'd3, 8'd200);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    fire(5'h10, woke, fl, mOk);
    check("R8", "pin wake", woke, 1);
    rd(2'd0, d);
    check("R8", "lockout busy bit", d[0], 1);
    wr(2'd0, 8'h01);
    #1;
    check("R8", "request held off", sysClkEn, 1);
    dropC = -1; offC = -1; violations = 0;
    regAddr = 2'd0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      #1;
      if (regRdData[0] && !sysClkEn) violations++;
      if (dropC < 0 && !regRdData[0]) dropC = c;
      if (offC < 0 && !sysClkEn) offC = c;
    end
    check("R8", "clock on during lockout", violations, 0);
    check("R8", "entry one cycle after expiry", offC - dropC, 1);
    fire(5'h01, woke, fl, mOk);
    check("R8", "wake after pending entry", woke, 1);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h1f);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule